// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block owns the refresh duty of an asynchronous DRAM array that supports CAS-before-RAS (CBR) refresh. After reset it keeps the strobes idle for a start-up delay and then runs a fixed number of CBR cycles to initialize the array. Only then does it raise a ready flag. From then on a tick is generated at an evenly spaced interval derived from the array's refresh budget, and each tick adds one to a saturating count of pending refreshes.

A host access engine shares the RAS/CAS/WE strobes with this block through a request/grant handshake. Once the host is granted, it keeps the bus for as long as it holds its request. Refresh work that falls due in that time is queued, up to a set limit. When the host lets go, the queued refreshes run back to back before the host can get the bus again. While the scheduler owns the strobes it drives them itself. WE is held high throughout, so a refresh can never be taken as a test-mode entry. Every timing value is given in nanoseconds and is rounded up to whole clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: Out of reset, ready_o, host_gnt_o, bus_own_o and ref_req_o are low and ras_no, cas_no and we_no are high. Neither strobe goes low until ceil(T_STARTUP_NS*1000/CLK_PERIOD_PS) clock cycles after reset release.
- R2: After the start-up wait, exactly INIT_CYCLES CBR cycles (counted as RAS falling edges) are issued before ready_o rises. ready_o never falls again until reset.
- R3: In every CBR cycle, cas_no is low for at least N(T_CSR_NS) cycles before ras_no falls. cas_no stays low for at least N(T_CHR_NS) cycles after the fall. ras_no stays low for at least N(T_RAS_NS) cycles and was high for at least N(T_RP_NS) cycles before the fall. N(t) is ceil(t*1000/CLK_PERIOD_PS), with a minimum of 1.
- R4: we_no is high whenever the block drives the strobes. It has been high for at least N(T_WRP_NS) cycles before each RAS fall, and it is still high when RAS rises.
- R5: Once ready, one refresh becomes due every N(T_REFI_NS) cycles. With the host idle, exactly one CBR cycle is issued per interval.
- R6: The pending-refresh count saturates at PEND_MAX. After a host hold that spans more intervals than PEND_MAX, exactly PEND_MAX CBR cycles are issued back to back once the host releases.
- R7: host_gnt_o is high only while ready_o is high, bus_own_o is low and both strobes are high.
- R8: Once granted, host_gnt_o stays high for as long as host_req_i is held, even with refreshes pending, and no CBR cycle starts during that time. host_gnt_o falls on the first clock edge after host_req_i is released.
- R9: ref_req_o is high exactly while at least one refresh is pending. It rises during a host hold that spans a tick and falls once the backlog is cleared.
- R10: When the bus is free and a refresh is pending, the block takes the bus in preference to the host. No pending refresh is lost while the count stays below PEND_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host requests or holds the DRAM strobes |
| host_gnt_o | output | 1 | Strobes granted to the host |
| ref_req_o | output | 1 | At least one refresh pending; asks the host to yield |
| ready_o | output | 1 | Initialization complete |
| bus_own_o | output | 1 | The scheduler is driving ras_no/cas_no/we_no |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low; held high by the scheduler |

## Verification
First the host holds its request from reset across start-up, initialization and five refresh intervals. This shows that no grant is given before ready, that the grant is not revoked, and that the pending count saturates instead of growing. An idle stretch of ten aligned intervals then pins down the refresh rate, separating one refresh per tick from a missed or doubled one. Seeded random host bursts, each shorter than one interval, interleave with ticks at every phase. A final tally of refreshes against ticks shows whether any refresh was dropped when the host and the scheduler competed for the same edge. Every CBR cycle seen along the way is measured against the setup, hold, pulse-width and precharge limits.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    SCH_WAIT,
    SCH_INIT,
    SCH_IDLE,
    SCH_HOST,
    SCH_REF
  } sch_state_e;

  typedef enum logic [2:0] {
    CBR_IDLE,
    CBR_PRE,
    CBR_CSR,
    CBR_ACT,
    CBR_REC
  } cbr_phase_e;

  // ns to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_timebase.sv
module ref_timebase #(
  parameter int N_START = 40000,
  parameter int N_REFI  = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic start_done_o,
  output logic tick_o
);
  localparam int SW = $clog2(N_START + 1);
  localparam int RW = (N_REFI > 1) ? $clog2(N_REFI) : 1;

  logic [SW-1:0] st_cnt_q;
  logic [RW-1:0] refi_q;
  logic          refi_wrap;

  assign start_done_o = (st_cnt_q == SW'(N_START));
  assign refi_wrap    = (refi_q == RW'(N_REFI - 1));
  assign tick_o       = en_i && refi_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_cnt_q <= '0;
    else if (!start_done_o) st_cnt_q <= st_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refi_q <= '0;
    else if (!en_i) refi_q <= '0;
    else if (refi_wrap) refi_q <= '0;
    else refi_q <= refi_q + 1'b1;
  end

  generate
    if (N_REFI > 1) begin : g_tick_chk
      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o) else $error("tick twice in a row"); // R5
    end
  endgenerate

  AST_NO_TICK_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> start_done_o) else $error("tick before start-up done"); // R1

endmodule

// File: rtl/ref_pend_ctr.sv
module ref_pend_ctr #(
  parameter int PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o
);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [PW-1:0] cnt_q;
  logic          full;

  assign full   = (cnt_q == PW'(PEND_MAX));
  assign pend_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (!full) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (pend_o) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && inc_i && !dec_i) |=> full) else $error("pending count wrapped"); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> pend_o) else $error("refresh retired with none pending"); // R10

endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
  import dram_ref_pkg::*;
#(
  parameter int N_PRE = 8,
  parameter int N_CSR = 2,
  parameter int N_ACT = 12,
  parameter int N_REC = 8,
  parameter int CW    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_no,
  output logic cas_no
);
  cbr_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    done_o  = 1'b0;
    unique case (phase_q)
      CBR_IDLE: if (start_i) begin
        phase_d = CBR_PRE;
        cnt_d   = CW'(N_PRE - 1);
      end
      CBR_PRE: if (last) begin
        phase_d = CBR_CSR;
        cnt_d   = CW'(N_CSR - 1);
      end
      CBR_CSR: if (last) begin
        phase_d = CBR_ACT;
        cnt_d   = CW'(N_ACT - 1);
      end
      CBR_ACT: if (last) begin
        phase_d = CBR_REC;
        cnt_d   = CW'(N_REC - 1);
      end
      CBR_REC: if (last) begin
        phase_d = CBR_IDLE;
        done_o  = 1'b1;
      end
      default: phase_d = CBR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= CBR_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (phase_q != CBR_IDLE);
  assign ras_no = (phase_q != CBR_ACT);
  assign cas_no = !((phase_q == CBR_CSR) || (phase_q == CBR_ACT));

  AST_CAS_LEADS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (!cas_no && $past(!cas_no))) else $error("RAS fell without CAS setup"); // R3
  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_no |-> !cas_no) else $error("CAS rose while RAS low"); // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o) else $error("start while busy"); // R10

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_STARTUP_NS  = 200000,
  parameter int T_REFI_NS     = 15625,
  parameter int INIT_CYCLES   = 8,
  parameter int PEND_MAX      = 8,
  parameter int T_RP_NS       = 40,
  parameter int T_RAS_NS      = 60,
  parameter int T_CSR_NS      = 10,
  parameter int T_CHR_NS      = 20,
  parameter int T_WRP_NS      = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_req_i,
  output logic host_gnt_o,
  output logic ref_req_o,
  output logic ready_o,
  output logic bus_own_o,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);
  localparam int N_START = ns_to_cyc(T_STARTUP_NS, CLK_PERIOD_PS);
  localparam int N_REFI  = ns_to_cyc(T_REFI_NS, CLK_PERIOD_PS);
  localparam int N_RP    = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int N_RAS   = ns_to_cyc(T_RAS_NS, CLK_PERIOD_PS);
  localparam int N_CSR   = ns_to_cyc(T_CSR_NS, CLK_PERIOD_PS);
  localparam int N_CHR   = ns_to_cyc(T_CHR_NS, CLK_PERIOD_PS);
  localparam int N_WRP   = ns_to_cyc(T_WRP_NS, CLK_PERIOD_PS);
  // WE is already high, so its setup folds into the precharge phase
  localparam int N_PRE   = max2(N_RP, N_WRP);
  localparam int N_ACT   = max2(N_RAS, N_CHR);
  localparam int N_REC   = N_RP;
  localparam int N_MAXPH = max2(max2(N_PRE, N_CSR), max2(N_ACT, N_REC));
  localparam int CW      = $clog2(N_MAXPH + 1);
  localparam int IW      = $clog2(INIT_CYCLES + 1);

  sch_state_e    state_q, state_d;
  logic [IW-1:0] init_q, init_d;
  logic          start_done, tick, pend;
  logic          seq_start, seq_busy, seq_done, pend_dec;

  ref_timebase #(
    .N_START(N_START),
    .N_REFI (N_REFI)
  ) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ready_o),
    .start_done_o(start_done),
    .tick_o      (tick)
  );

  ref_pend_ctr #(
    .PEND_MAX(PEND_MAX)
  ) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (tick),
    .dec_i (pend_dec),
    .pend_o(pend)
  );

  cbr_seq #(
    .N_PRE(N_PRE),
    .N_CSR(N_CSR),
    .N_ACT(N_ACT),
    .N_REC(N_REC),
    .CW   (CW)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(seq_start),
    .busy_o (seq_busy),
    .done_o (seq_done),
    .ras_no (ras_no),
    .cas_no (cas_no)
  );

  always_comb begin
    state_d   = state_q;
    init_d    = init_q;
    seq_start = 1'b0;
    unique case (state_q)
      SCH_WAIT: if (start_done) state_d = SCH_INIT;
      SCH_INIT: begin
        seq_start = !seq_busy;
        if (seq_done) begin
          init_d = init_q + 1'b1;
          if (init_q == IW'(INIT_CYCLES - 1)) state_d = SCH_IDLE;
        end
      end
      SCH_IDLE: begin
        // refresh wins a free bus
        if (pend) begin
          seq_start = 1'b1;
          state_d   = SCH_REF;
        end else if (host_req_i) begin
          state_d = SCH_HOST;
        end
      end
      SCH_HOST: if (!host_req_i) state_d = SCH_IDLE;
      SCH_REF:  if (seq_done) state_d = SCH_IDLE;
      default:  state_d = SCH_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCH_WAIT;
      init_q  <= '0;
    end else begin
      state_q <= state_d;
      init_q  <= init_d;
    end
  end

  assign pend_dec   = seq_done && (state_q == SCH_REF);
  assign ready_o    = (state_q == SCH_IDLE) || (state_q == SCH_HOST) || (state_q == SCH_REF);
  assign host_gnt_o = (state_q == SCH_HOST);
  assign bus_own_o  = seq_busy;
  assign ref_req_o  = pend;
  assign we_no      = 1'b1;

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o) else $error("ready dropped"); // R2
  AST_GNT_NOT_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> (!bus_own_o && ras_no && cas_no)) else $error("grant while strobes owned"); // R7
  AST_GNT_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> ready_o) else $error("grant before ready"); // R7
  AST_GNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_gnt_o && host_req_i) |=> host_gnt_o) else $error("grant revoked"); // R8
  AST_GNT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_gnt_o && !host_req_i) |=> !host_gnt_o) else $error("grant kept after release"); // R8
  AST_REF_TAKES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !host_gnt_o && !bus_own_o && ref_req_o) |=> bus_own_o) else $error("pending refresh not started"); // R10

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int CLK_PS   = 5000;
  localparam int START_NS = 2000;
  localparam int REFI_NS  = 1500;
  localparam int INIT_N   = 8;
  localparam int PMAX     = 4;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_START = cyc_of(START_NS);
  localparam int E_REFI  = cyc_of(REFI_NS);
  localparam int E_RP    = cyc_of(40);
  localparam int E_RAS   = cyc_of(60);
  localparam int E_CSR   = cyc_of(10);
  localparam int E_CHR   = cyc_of(20);
  localparam int E_WRP   = cyc_of(10);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0;
  logic host_gnt, ref_req, ready, bus_own, ras_n, cas_n, we_n;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PERIOD_PS(CLK_PS),
    .T_STARTUP_NS (START_NS),
    .T_REFI_NS    (REFI_NS),
    .INIT_CYCLES  (INIT_N),
    .PEND_MAX     (PMAX)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .host_req_i(host_req),
    .host_gnt_o(host_gnt),
    .ref_req_o (ref_req),
    .ready_o   (ready),
    .bus_own_o (bus_own),
    .ras_no    (ras_n),
    .cas_no    (cas_n),
    .we_no     (we_n)
  );

  int cyc = 0;
  int errs = 0;
  int checks = 0;
  int falls = 0;
  int init_falls = 0;
  int ready_cyc = -1;
  int rst_cyc = 0;
  int first_act = -1;
  int excl_bad = 0, hold_bad = 0, ready_drop = 0, we_bad = 0;
  int cas_low_run = 0, ras_high_run = 0, ras_low_run = 0, chr_run = 0, we_high_run = 0;
  logic ras_prev = 1'b1, req_prev = 1'b0, gnt_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) step();
  endtask

  // protocol monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && ras_prev) begin
        falls++;
        chk(cas_low_run >= E_CSR, "R3 CAS setup before RAS", cas_low_run, E_CSR);
        chk(ras_high_run >= E_RP, "R3 RAS precharge", ras_high_run, E_RP);
        chk(we_high_run >= E_WRP, "R4 WE setup before RAS", we_high_run, E_WRP);
        chr_run = 0;
      end
      if (ras_n && !ras_prev) begin
        chk(ras_low_run >= E_RAS, "R3 RAS pulse width", ras_low_run, E_RAS);
        chk(chr_run >= E_CHR, "R3 CAS hold after RAS", chr_run, E_CHR);
        chk(we_n == 1'b1, "R4 WE hold at RAS rise", int'(we_n), 1);
      end
      if (!ras_n && !cas_n && chr_run == ras_low_run) chr_run++;
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      we_high_run  = we_n ? we_high_run + 1 : 0;
      if (!we_n) we_bad++;
      if (host_gnt && (!ras_n || !cas_n || bus_own || !ready)) excl_bad++;
      if (req_prev && gnt_prev && !host_gnt) hold_bad++;
      if (first_act < 0 && (!ras_n || !cas_n)) first_act = cyc;
      if (ready && ready_cyc < 0) begin
        ready_cyc  = cyc;
        init_falls = falls;
      end
      if (ready_cyc >= 0 && !ready) ready_drop++;
      ras_prev = ras_n;
      req_prev = host_req;
      gnt_prev = host_gnt;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int f0, f1, m, gnt_low, s;
    s = $urandom(32'h5EED);
    repeat (4) step();
    chk(ready == 0 && host_gnt == 0 && bus_own == 0 && ref_req == 0, "R1 reset outputs low",
        int'({ready, host_gnt, bus_own, ref_req}), 0);
    chk(ras_n && cas_n && we_n, "R1 reset strobes high", int'({ras_n, cas_n, we_n}), 7);
    rst_n = 1'b1;
    rst_cyc = cyc;
    host_req = 1'b1;   // held from reset on: no grant may appear early
    while (ready_cyc < 0) step();
    chk(first_act - rst_cyc >= E_START, "R1 start-up wait", first_act - rst_cyc, E_START);
    chk(init_falls == INIT_N, "R2 init cycle count", init_falls, INIT_N);
    step();
    chk(host_gnt == 1'b1, "R8 grant after ready", int'(host_gnt), 1);
    gnt_low = 0;
    while (cyc < ready_cyc + 5 * E_REFI + 10) begin
      step();
      if (!host_gnt) gnt_low++;
      if (cyc == ready_cyc + E_REFI + 20)
        chk(ref_req == 1'b1, "R9 ref request during hold", int'(ref_req), 1);
    end
    chk(gnt_low == 0, "R8 grant held through hold", gnt_low, 0);
    chk(falls == init_falls, "R8 no refresh while host holds", falls - init_falls, 0);
    f0 = falls;
    host_req = 1'b0;
    step();
    chk(host_gnt == 1'b0, "R8 grant released", int'(host_gnt), 0);
    wait_until(ready_cyc + 5 * E_REFI + 160);
    chk(falls - f0 == PMAX, "R6 capped catch-up", falls - f0, PMAX);
    chk(ref_req == 1'b0, "R9 backlog cleared", int'(ref_req), 0);
    wait_until(ready_cyc + 6 * E_REFI + 100);
    f1 = falls;
    wait_until(ready_cyc + 16 * E_REFI + 100);
    chk(falls - f1 == 10, "R5 refresh rate idle", falls - f1, 10);
    for (int i = 0; i < 15; i++) begin
      int len, gap;
      len = 1 + int'($urandom_range(249));
      gap = 1 + int'($urandom_range(59));
      host_req = 1'b1;
      repeat (len) step();
      host_req = 1'b0;
      repeat (gap) step();
    end
    m = (cyc - ready_cyc) / E_REFI + 2;
    wait_until(ready_cyc + m * E_REFI + 150);
    chk(falls - init_falls == m - 1, "R10 no refresh lost", falls - init_falls, m - 1);
    chk(ref_req == 1'b0, "R9 idle after random", int'(ref_req), 0);
    chk(excl_bad == 0, "R7 grant exclusive", excl_bad, 0);
    chk(hold_bad == 0, "R8 grant never revoked", hold_bad, 0);
    chk(ready_drop == 0, "R2 ready sticky", ready_drop, 0);
    chk(we_bad == 0, "R4 WE always high", we_bad, 0);
    summary();
    $finish;
  end

endmodule